// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Level Flags

This block is a first-in first-out queue for one clock domain. Words enter through a write strobe and leave through a read strobe. The storage is an inferred dual-port memory with a registered read port. Four level flags are provided: full, empty, and two threshold flags whose levels are set by parameters. A write that hits a full queue and a read that hits an empty queue are dropped, and each is reported by a one-cycle pulse.

Parameters fix the configuration when the block is elaborated. They set the word width (4, 9, 18, 36, or 72 bits, where 72 needs the wide option), the memory depth, and both thresholds. They also select the output behaviour, which is either standard (data shows only after a read) or look-ahead (the oldest word already sits on the output). The output stage is one of three kinds: no extra register; an automatic register that the queue loads itself, which holds one more word; or a pipeline register driven by a user enable and a user clear. The data output comes out of reset at a parameter value.

Before the body is built, an elaboration check rejects an illegal width. It also rejects thresholds that are out of order or larger than the capacity.

Top module: `pfifo`

## Requirements
- R1: Occupancy is the number of accepted writes minus the number of accepted reads. `full` is high exactly when occupancy equals the capacity CAP = 2^AW + (1 if look-ahead) + (1 if automatic register). The automatic register therefore adds one word over the plain output.
- R2: `prog_full` is high exactly when occupancy >= PF_LVL.
- R3: `prog_empty` is high exactly when occupancy <= PE_LVL.
- R4: When `wr_en` is high while `full` is high, the write is dropped and stored contents do not change. `overflow` is high for the one cycle after that edge.
- R5: When `rd_en` is high while `empty` is high, the read is dropped and nothing is removed. `underflow` is high for the one cycle after that edge.
- R6: Words leave in the order they were accepted, and none is lost or repeated.
- R7: Standard mode. A word accepted at edge k can be popped after edge k with no register, or after edge k+1 with the automatic register. `empty` is low exactly while the oldest word can be popped. After an accepted read, `rd_data` shows the popped word and holds it until the next accepted read.
- R8: Look-ahead mode. A word accepted at edge k is shown on `rd_data`, with `empty` low, after edge k+1 with no register, or after edge k+2 with the automatic register. This holds once all older words have left. A read shows the next ready word after the same edge. While `empty` is high, `rd_data` keeps the last word shown.
- R9: Pipeline-register mode. At each edge `rd_data` loads the unregistered output when `oreg_ce` is high. It loads INIT_VAL when `oreg_clr` is high, and the clear wins over the enable. In the other modes both inputs have no effect.
- R10: While `rst` is high at an edge, the block resets. Afterwards `rd_data` = INIT_VAL, `empty` = 1, `full` = 0, `prog_empty` = 1, `prog_full` = 0, `overflow` = 0 and `underflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| full | output | 1 | Occupancy equals capacity |
| prog_full | output | 1 | Occupancy at or above PF_LVL |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Output word |
| empty | output | 1 | No word ready to pop |
| prog_empty | output | 1 | Occupancy at or below PE_LVL |
| underflow | output | 1 | One-cycle pulse after a dropped read |
| oreg_ce | input | 1 | Pipeline-register load enable |
| oreg_clr | input | 1 | Pipeline-register clear to INIT_VAL |

## Verification
The hardest state to reach is the look-ahead chain with the automatic register filled to capacity. In that state the memory, the prefetch latch and the output register all hold words, and a read must ripple through all three at one edge. Reads that land while a freshly written word is still crossing the chain are also hard to hit. The stimulus reaches these states with a directed burst that overfills the queue, a burst that drains it past empty, and then random phases with shifting write and read rates. The phases hover the level around the full and empty points, so that reads often land while a word is still crossing the chain.

// File: rtl/pfifo_pkg.sv
`timescale 1ns/1ps
package pfifo_pkg;
  typedef enum logic [1:0] {
    OREG_NONE = 2'd0,
    OREG_AUTO = 2'd1,
    OREG_PIPE = 2'd2
  } oreg_mode_e;

  function automatic bit width_ok(int w, bit wide);
    return (w == 4) || (w == 9) || (w == 18) || (w == 36) || ((w == 72) && wide);
  endfunction

  // words held outside the memory by the output chain
  function automatic int extra_stages(bit fwft, oreg_mode_e m);
    return (fwft ? 1 : 0) + ((m == OREG_AUTO) ? 1 : 0);
  endfunction
endpackage

// File: rtl/pfifo_ram.sv
`timescale 1ns/1ps
module pfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 4,
  parameter logic [DW-1:0] INIT_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; its latch resets to the start-up word
  always_ff @(posedge clk) begin
    if (rst)     rdata <= INIT_VAL;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfifo_level.sv
`timescale 1ns/1ps
module pfifo_level #(
  parameter int CAP = 18,
  parameter int PE_LVL = 3,
  parameter int PF_LVL = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic prog_full,
  output logic prog_empty
);
  localparam int CW = $clog2(CAP + 1);

  logic [CW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + CW'(inc) - CW'(dec);
  end

  assign full       = (occ == CW'(CAP));
  assign prog_full  = (occ >= CW'(PF_LVL));
  assign prog_empty = (occ <= CW'(PE_LVL));

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst) occ <= CW'(CAP));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) dec |-> occ != '0);
endmodule

// File: rtl/pfifo_preg.sv
`timescale 1ns/1ps
module pfifo_preg #(
  parameter int DW = 18,
  parameter logic [DW-1:0] INIT_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          clr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= INIT_VAL;
    else if (ce)    q <= d;
  end

  // R9
  preg_clear_chk: assert property (@(posedge clk) disable iff (rst) clr |=> q == INIT_VAL);
endmodule

// File: rtl/pfifo.sv
`timescale 1ns/1ps
module pfifo #(
  parameter int DW = 18,
  parameter int AW = 4,
  parameter bit WIDE = 1'b0,
  parameter bit FWFT = 1'b1,
  parameter pfifo_pkg::oreg_mode_e OREG = pfifo_pkg::OREG_AUTO,
  parameter int PE_LVL = 3,
  parameter int PF_LVL = 14,
  parameter logic [DW-1:0] INIT_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          prog_full,
  output logic          overflow,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          prog_empty,
  output logic          underflow,
  input  logic          oreg_ce,
  input  logic          oreg_clr
);
  localparam int DEPTH  = 1 << AW;
  localparam int STAGES = pfifo_pkg::extra_stages(FWFT, OREG);
  localparam int CAP    = DEPTH + STAGES;

  if (!pfifo_pkg::width_ok(DW, WIDE)) begin : g_bad_width
    $error("pfifo: DW must be 4, 9, 18, 36, or 72 (72 only with WIDE)");
  end
  if (!(PE_LVL < PF_LVL && PF_LVL <= CAP && PE_LVL >= 0)) begin : g_bad_levels
    $error("pfifo: need 0 <= PE_LVL < PF_LVL <= capacity");
  end

  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   mcnt;
  logic          wr_ok, rd_ok, fetch, empty_i;
  logic [DW-1:0] ram_q, stage_q;

  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty_i;

  pfifo_ram #(.DW(DW), .AW(AW), .INIT_VAL(INIT_VAL)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_ok), .waddr(wptr), .wdata(wr_data),
    .re(fetch), .raddr(rptr), .rdata(ram_q)
  );

  pfifo_level #(.CAP(CAP), .PE_LVL(PE_LVL), .PF_LVL(PF_LVL)) u_level (
    .clk(clk), .rst(rst), .inc(wr_ok), .dec(rd_ok),
    .full(full), .prog_full(prog_full), .prog_empty(prog_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      mcnt <= '0;
    end else begin
      wptr <= wptr + AW'(wr_ok);
      rptr <= rptr + AW'(fetch);
      mcnt <= mcnt + (AW+1)'(wr_ok) - (AW+1)'(fetch);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= wr_en & full;
      underflow <= rd_en & empty_i;
    end
  end

  if (STAGES == 0) begin : g_plain
    // standard output, memory read only on a pop
    assign fetch   = rd_ok;
    assign empty_i = (mcnt == '0);
    assign stage_q = ram_q;
  end else if (STAGES == 1) begin : g_one
    logic bv;
    assign fetch   = (mcnt != '0) & (~bv | rd_ok);
    assign empty_i = ~bv;
    always_ff @(posedge clk) begin
      if (rst) bv <= 1'b0;
      else     bv <= fetch | (bv & ~rd_ok);
    end
    if (FWFT) begin : g_direct
      assign stage_q = ram_q;
      // R8
      head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !empty_i && !rd_en |=> $stable(stage_q));
    end else begin : g_popreg
      logic [DW-1:0] oq;
      always_ff @(posedge clk) begin
        if (rst)        oq <= INIT_VAL;
        else if (rd_ok) oq <= ram_q;
      end
      assign stage_q = oq;
    end
  end else begin : g_two
    logic bv, ov, move;
    logic [DW-1:0] oq;
    assign move    = bv & (~ov | rd_ok);
    assign fetch   = (mcnt != '0) & (~bv | move);
    assign empty_i = ~ov;
    always_ff @(posedge clk) begin
      if (rst) begin
        bv <= 1'b0;
        ov <= 1'b0;
        oq <= INIT_VAL;
      end else begin
        bv <= fetch | (bv & ~move);
        ov <= move | (ov & ~rd_ok);
        if (move) oq <= ram_q;
      end
    end
    assign stage_q = oq;
    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !empty_i && !rd_en |=> $stable(stage_q));
  end

  if (OREG == pfifo_pkg::OREG_PIPE) begin : g_pipe
    pfifo_preg #(.DW(DW), .INIT_VAL(INIT_VAL)) u_preg (
      .clk(clk), .rst(rst), .ce(oreg_ce), .clr(oreg_clr),
      .d(stage_q), .q(rd_data)
    );
  end else begin : g_nopipe
    logic unused_ctl;
    assign unused_ctl = oreg_ce | oreg_clr;
    assign rd_data    = stage_q;
  end

  assign empty = empty_i;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && full |=> $stable(wptr));
  // R1
  mem_room_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> mcnt < (AW+1)'(DEPTH));
  // R6
  ptr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (wptr - rptr) == AW'(mcnt));
endmodule

// File: tb/pfifo_test.sv
`timescale 1ns/1ps
module pfifo_lane #(
  parameter bit FWFT = 1'b0,
  parameter pfifo_pkg::oreg_mode_e OREG = pfifo_pkg::OREG_NONE,
  parameter int SEED = 1
) (
  input  logic clk,
  output bit   done,
  output int   n_chk,
  output int   n_err
);
  localparam int DW = 18;
  localparam int AW = 3;
  localparam logic [DW-1:0] INIT = 18'h2A5C3;
  localparam int S   = (FWFT ? 1 : 0) + ((OREG == pfifo_pkg::OREG_AUTO) ? 1 : 0);
  localparam int CAP = (1 << AW) + S;
  localparam int PE  = 2;
  localparam int PF  = CAP - 2;
  localparam bit PIPE = (OREG == pfifo_pkg::OREG_PIPE);

  logic rst, wr_en, rd_en, oce, oclr;
  logic [DW-1:0] wdat, rdat;
  logic full, pfull, ovf, empty, pempty, udf;

  pfifo #(.DW(DW), .AW(AW), .FWFT(FWFT), .OREG(OREG), .PE_LVL(PE), .PF_LVL(PF),
          .INIT_VAL(INIT)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wdat), .full(full),
    .prog_full(pfull), .overflow(ovf), .rd_en(rd_en), .rd_data(rdat),
    .empty(empty), .prog_empty(pempty), .underflow(udf),
    .oreg_ce(oce), .oreg_clr(oclr)
  );

  logic [DW-1:0] q_d[$];
  int            q_t[$];
  int            cyc;
  logic [DW-1:0] last_pop, preg_m;
  bit            ovf_m, udf_m;

  function automatic bit vis();
    if (q_d.size() == 0) return 1'b0;
    return (cyc - q_t[0]) >= S;
  endfunction

  function automatic logic [DW-1:0] inner_m();
    if (FWFT && vis()) return q_d[0];
    return last_pop;
  endfunction

  task automatic chk(input string req, input string what, input logic [71:0] act,
                     input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s lane fwft=%0d mode=%0d %s: got %h expected %h",
               req, FWFT, OREG, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(FWFT ? "R8" : "R7", "empty", empty, !vis());
    chk("R1", "full", full, q_d.size() == CAP);
    chk("R2", "prog_full", pfull, q_d.size() >= PF);
    chk("R3", "prog_empty", pempty, q_d.size() <= PE);
    chk("R4", "overflow", ovf, ovf_m);
    chk("R5", "underflow", udf, udf_m);
    chk(PIPE ? "R6 R9" : (FWFT ? "R6 R8" : "R6 R7"), "rd_data", rdat,
        PIPE ? preg_m : inner_m());
  endtask

  // called at a falling edge; ends at the next falling edge after checking
  task automatic step(input bit w, input bit r, input bit ce, input bit clr,
                      input logic [DW-1:0] d);
    bit acc_w, acc_r, ovf_n, udf_n;
    logic [DW-1:0] in_pre;
    wr_en = w; rd_en = r; oce = ce; oclr = clr; wdat = d;
    acc_w  = w && (q_d.size() != CAP);
    acc_r  = r && vis();
    ovf_n  = w && (q_d.size() == CAP);
    udf_n  = r && !vis();
    in_pre = inner_m();
    @(posedge clk);
    cyc++;
    if (acc_r) begin
      last_pop = q_d.pop_front();
      void'(q_t.pop_front());
    end
    if (acc_w) begin
      q_d.push_back(d);
      q_t.push_back(cyc);
    end
    if (clr)     preg_m = INIT;
    else if (ce) preg_m = in_pre;
    ovf_m = ovf_n;
    udf_m = udf_n;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_err = 0;
    void'($urandom(SEED));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; oce = 1'b0; oclr = 1'b0; wdat = '0;
    cyc = 0; last_pop = INIT; preg_m = INIT; ovf_m = 1'b0; udf_m = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "rd_data", rdat, INIT);
    chk("R10", "empty", empty, 1'b1);
    chk("R10", "full", full, 1'b0);
    chk("R10", "prog_empty", pempty, 1'b1);
    chk("R10", "prog_full", pfull, 1'b0);
    chk("R10", "overflow", ovf, 1'b0);
    chk("R10", "underflow", udf, 1'b0);
    rst = 1'b0;
    // overfill past capacity (R1, R2, R4)
    for (int i = 0; i < CAP + 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, DW'($urandom));
    // drain past empty (R3, R5, R6)
    for (int i = 0; i < CAP + 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0, '0);
    // clear and enable together: clear wins (R9)
    step(1'b1, 1'b1, 1'b1, 1'b1, DW'($urandom));
    step(1'b1, 1'b0, 1'b1, 1'b1, DW'($urandom));
    // random phases with shifting rates
    for (int ph = 0; ph < 4; ph++) begin
      int pw, pr;
      pw = (ph == 0) ? 85 : (ph == 2) ? 20 : 55;
      pr = (ph == 0) ? 25 : (ph == 2) ? 85 : 50;
      for (int i = 0; i < 150; i++)
        step($urandom_range(99, 0) < pw, $urandom_range(99, 0) < pr,
             $urandom_range(99, 0) < 60, $urandom_range(99, 0) < 8, DW'($urandom));
    end
    wr_en = 1'b0; rd_en = 1'b0;
    done = 1'b1;
  end
endmodule

module pfifo_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  bit  dn [6];
  int  nc [6];
  int  ne [6];

  pfifo_lane #(.FWFT(1'b0), .OREG(pfifo_pkg::OREG_NONE), .SEED(11)) l0 (clk, dn[0], nc[0], ne[0]);
  pfifo_lane #(.FWFT(1'b0), .OREG(pfifo_pkg::OREG_AUTO), .SEED(22)) l1 (clk, dn[1], nc[1], ne[1]);
  pfifo_lane #(.FWFT(1'b0), .OREG(pfifo_pkg::OREG_PIPE), .SEED(33)) l2 (clk, dn[2], nc[2], ne[2]);
  pfifo_lane #(.FWFT(1'b1), .OREG(pfifo_pkg::OREG_NONE), .SEED(44)) l3 (clk, dn[3], nc[3], ne[3]);
  pfifo_lane #(.FWFT(1'b1), .OREG(pfifo_pkg::OREG_AUTO), .SEED(55)) l4 (clk, dn[4], nc[4], ne[4]);
  pfifo_lane #(.FWFT(1'b1), .OREG(pfifo_pkg::OREG_PIPE), .SEED(66)) l5 (clk, dn[5], nc[5], ne[5]);

  initial begin
    int cycles, checks, errors;
    bit all_done;
    cycles = 0;
    all_done = 1'b0;
    while (!all_done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
      all_done = dn[0] & dn[1] & dn[2] & dn[3] & dn[4] & dn[5];
    end
    checks = 0;
    errors = 0;
    for (int i = 0; i < 6; i++) begin
      checks += nc[i];
      errors += ne[i];
    end
    if (!all_done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: lanes done %b%b%b%b%b%b expected 111111",
               dn[5], dn[4], dn[3], dn[2], dn[1], dn[0]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule